// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host writes bytes into a queue of up to sixteen entries. A shift stage takes each byte from the head of the queue and sends it on a single line as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Bit timing comes from an oversampling enable pulse supplied from outside at sixteen times the bit rate. The block does not generate baud rates.

The host sees two separate emptiness indications. The first reports that the queue has nothing waiting. The second reports that the queue and the shift stage are both idle, so the line has gone quiet. An interrupt request goes high while the queue fill level is under a selectable threshold, and only when the interrupt is enabled. When the queue is switched off, the block acts like a classic single holding register in front of the shifter.

Top module: `sertx_top`

## Requirements
- R1: During reset and directly after it, `tx` is 1, `hold_empty` is 1 and `tx_empty` is 1. With `irq_en` low, `irq` is 0.
- R2: A frame is a 0 start bit, then data bits LSB first, then an optional parity bit, then stop bits of 1. `data_bits` selects the data length: 00=5, 01=6, 10=7, 11=8. When `parity_en`=1 a parity bit follows the data. With `parity_odd`=0 the data bits plus the parity bit hold an even number of ones; with `parity_odd`=1 they hold an odd number. `two_stop`=1 gives two stop bits, 0 gives one.
- R3: Every bit of a frame stays on `tx` for exactly 16 `tick16` pulses. The shifter is still busy until the last of those pulses for the final stop bit.
- R4: In queue mode (`fifo_mode`=1) up to 16 bytes are held, and they are sent in the order they were written.
- R5: A write while the queue is full is dropped, and the stored bytes are unchanged.
- R6: `hold_empty` is 1 exactly when the queue holds no byte. A byte moves into the shifter one cycle after it arrives if the shifter is idle.
- R7: `tx_empty` is 1 only when the queue is empty and no frame is in progress.
- R8: `irq` equals `irq_en` AND (fill level < threshold). `trig_sel` selects the threshold: 00=1, 01=4, 10=8, 11=14. An empty queue therefore always requests when enabled.
- R9: With `irq_en`=0, `irq` stays 0.
- R10: With `fifo_mode`=0 the queue holds one byte, a write while that byte is held is dropped, and the threshold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1 = 16-entry queue, 0 = single holding byte |
| trig_sel | input | 2 | Interrupt threshold select |
| irq_en | input | 1 | Interrupt enable |
| data_bits | input | 2 | Data length code |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | Odd parity when 1 |
| two_stop | input | 1 | Two stop bits when 1 |
| tx | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue and shifter both empty |
| irq | output | 1 | Transmit interrupt request |

## Verification
The shifter empties the queue as fast as it fills, so the fill levels that decide the threshold and the full-queue drop are hard to reach. The bench stops the oversampling pulses. This freezes the first byte inside the shifter. The bench then writes bytes one at a time and compares `irq` for every threshold code at the fill levels 3, 4, 8, 14 and 16, and then makes a seventeenth write that must be lost. When the pulses restart, the scoreboard checks that exactly the accepted bytes come out, in order, and that none of them was overwritten.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int OVS       = 16;
    localparam int FRAME_MAX = 12;
    localparam int FLEN_W    = 4;
    localparam int BYTE_W    = 8;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [FLEN_W-1:0]    len;
    } frame_t;

    // Threshold in entries for each select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // Whole frame, bit 0 first on the line; unused upper bits are idle ones
    function automatic frame_t build_frame(input frame_cfg_t cfg, input logic [BYTE_W-1:0] data);
        frame_t f;
        int     nd;
        logic   par;
        nd     = 5 + int'(cfg.len_code);
        f.bits = '1;
        f.bits[0] = 1'b0;
        par    = cfg.par_odd;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < nd) begin
                f.bits[1+i] = data[i];
                par         = par ^ data[i];
            end
        end
        if (cfg.par_en) f.bits[1+nd] = par;
        f.len = FLEN_W'(2 + nd + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 1 : 0));
        return f;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          cap_one,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = cap_one ? !empty : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter  int OVS_N = OVS,
    localparam int TW    = $clog2(OVS_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic [BYTE_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    logic [FRAME_MAX-1:0] sh;
    logic [FLEN_W-1:0]    left;
    logic [TW-1:0]        tcnt;
    frame_t               nf;

    assign nf   = build_frame(cfg, data);
    assign take = !busy && avail;
    assign txd  = (busy && !rst) ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            tcnt <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sh   <= nf.bits;
            left <= nf.len;
            tcnt <= '0;
        end else if (busy && tick) begin
            if (tcnt == TW'(OVS_N - 1)) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - FLEN_W'(1);
                if (left == FLEN_W'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
    import sertx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] fill,
    input  logic          fifo_mode,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          irq
);

    logic [CW-1:0] thr;

    assign thr = fifo_mode ? CW'(trig_level(trig_sel)) : CW'(1);
    assign irq = irq_en && (fill < thr);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              fifo_mode,
    input  logic [1:0]        trig_sel,
    input  logic              irq_en,
    input  logic [1:0]        data_bits,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    output logic              tx,
    output logic              hold_empty,
    output logic              tx_empty,
    output logic              irq
);

    frame_cfg_t        cfg;
    logic [BYTE_W-1:0] head;
    logic [CW-1:0]     fill;
    logic              q_empty, take, busy;

    assign cfg = '{len_code: data_bits, par_en: parity_en,
                   par_odd: parity_odd, two_stop: two_stop};

    sertx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(take),
        .cap_one(!fifo_mode), .dout(head), .count(fill), .empty(q_empty)
    );

    sertx_shifter #(.OVS_N(OVS)) u_shift (
        .clk(clk), .rst(rst), .tick(tick16), .avail(!q_empty), .data(head),
        .cfg(cfg), .take(take), .busy(busy), .txd(tx)
    );

    sertx_irq #(.CW(CW)) u_irq (
        .fill(fill), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
        .irq_en(irq_en), .irq(irq)
    );

    assign hold_empty = q_empty;
    assign tx_empty   = q_empty && !busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic tick16,
    input logic irq_en,
    input logic tx,
    input logic hold_empty,
    input logic tx_empty,
    input logic irq
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> tx);                                           // R1
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst) (armed && tx_empty) |-> tx);          // R7
    AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (rst) (armed && !hold_empty) |-> !tx_empty); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) !irq_en |-> !irq);                     // R9
    AST_IRQ_ON_EMPTY: assert property (@(posedge clk) disable iff (rst) (armed && irq_en && hold_empty) |-> irq); // R8
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !$past(tx) && !$past(tick16)) |-> !tx);                                   // R3

endmodule

bind sertx_top sertx_checker i_chk (
    .clk(clk), .rst(rst), .tick16(tick16), .irq_en(irq_en), .tx(tx),
    .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_mode = 1'b1;
    logic [1:0] trig_sel = '0;
    logic       irq_en = 1'b0;
    logic [1:0] data_bits = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       tx, hold_empty, tx_empty, irq;

    sertx_top i_sertx_top (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .trig_sel(trig_sel), .irq_en(irq_en),
        .data_bits(data_bits), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .tx(tx), .hold_empty(hold_empty),
        .tx_empty(tx_empty), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [11:0] bits;
        int          len;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_err = 0;
    int   cyc = 0;
    bit   tick_run = 1'b0;
    int   div = 0;
    int   tk_total = 0;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Oversampling pulse every 4 clocks while running
    always @(negedge clk) begin
        if (tick_run) begin
            div    = (div == 3) ? 0 : div + 1;
            tick16 = (div == 3);
        end else begin
            tick16 = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (tick16) tk_total++;
        if (cyc > 180000) begin
            n_err++;
            $display("FAIL watchdog expired, all requirements");
            summary();
        end
    end

    // Expected frame, built from R2
    function automatic exp_t mk(input logic [7:0] d);
        exp_t e;
        int   nd;
        bit   p;
        nd     = 5 + int'(data_bits);
        e.bits = '1;
        e.bits[0] = 1'b0;
        p = parity_odd;
        for (int i = 0; i < nd; i++) begin
            e.bits[1+i] = d[i];
            p = p ^ d[i];
        end
        e.len = 2 + nd + int'(two_stop);
        if (parity_en) begin
            e.bits[1+nd] = p;
            e.len++;
        end
        return e;
    endfunction

    // Driver: one write; the expected frame is queued only if the write is kept
    task automatic put(input logic [7:0] d, input bit kept);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (kept) sb.push_back(mk(d));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_fmt(input logic [1:0] db, input bit pe, input bit po, input bit ts);
        @(negedge clk);
        data_bits  = db;
        parity_en  = pe;
        parity_odd = po;
        two_stop   = ts;
    endtask

    // Monitor / scoreboard
    bit          mbusy = 1'b0;
    int          base, tcnt, idx, cur_len;
    bit          r3_done;
    logic [11:0] got;
    exp_t        cur;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mbusy && tx == 1'b0) begin
                mbusy   = 1'b1;
                base    = tk_total;
                idx     = 0;
                got     = '1;
                r3_done = 1'b0;
                if (sb.size() == 0) begin
                    check(1'b0, "R4/R5 unexpected frame", 1, 0);
                    cur.bits = '1;
                    cur.len  = 1;
                end else begin
                    cur = sb[0];
                end
                cur_len = cur.len;
            end
            if (mbusy) begin
                tcnt = tk_total - base;
                if (idx < cur_len && tcnt == 8 + 16 * idx) begin
                    got[idx] = tx;
                    idx++;
                end
                if (!r3_done && tcnt == 16 * cur_len - 1) begin
                    r3_done = 1'b1;
                    check(!tx_empty, "R3 shifter busy through last tick", int'(tx_empty), 0);
                end
                if (tcnt >= 16 * cur_len) begin
                    bit same;
                    same = 1'b1;
                    for (int i = 0; i < cur_len; i++) if (got[i] !== cur.bits[i]) same = 1'b0;
                    check(same, "R2/R4 frame bits", int'(got), int'(cur.bits));
                    if (sb.size() != 0) void'(sb.pop_front());
                    mbusy = 1'b0;
                end
            end
        end
    end

    task automatic drain(input string tag);
        int g;
        g = 0;
        tick_run = 1'b1;
        while ((sb.size() != 0 || mbusy || !tx_empty) && g < 30000) begin
            @(negedge clk);
            g++;
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, tag, sb.size(), 0);
        check(tx_empty && hold_empty && tx, "R7 idle after drain", int'({tx_empty, hold_empty, tx}), 7);
    endtask

    initial begin
        int lvl[4];
        int fill;
        lvl[0] = 1; lvl[1] = 4; lvl[2] = 8; lvl[3] = 14;

        repeat (3) @(negedge clk);
        check(tx === 1'b1, "R1 tx high in reset", int'(tx), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx === 1'b1, "R1 tx after reset", int'(tx), 1);
        check(hold_empty === 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
        check(tx_empty === 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
        check(irq === 1'b0, "R1 R9 irq low when disabled", int'(irq), 0);

        // R2 R3 R4: several frame formats
        set_fmt(2'd3, 0, 0, 0);
        put(8'hA5, 1); put(8'h3C, 1);
        drain("R4 8N1 frames delivered");
        set_fmt(2'd2, 1, 0, 0);
        put(8'h55, 1); put(8'h0F, 1);
        drain("R2 7E1 frames delivered");
        set_fmt(2'd0, 1, 1, 1);
        put(8'h13, 1); put(8'h1F, 1);
        drain("R2 5O2 frames delivered");
        set_fmt(2'd1, 1, 0, 1);
        put(8'h2A, 1);
        drain("R2 6E2 frames delivered");
        set_fmt(2'd3, 1, 1, 0);
        put(8'hFF, 1); put(8'h00, 1);
        drain("R2 8O1 frames delivered");

        // R6 R7: flags with the shifter frozen
        tick_run = 1'b0;
        repeat (8) @(negedge clk);
        put(8'h81, 1);
        @(negedge clk);
        check(hold_empty === 1'b1, "R6 byte moved to shifter", int'(hold_empty), 1);
        check(tx_empty === 1'b0, "R7 shifter busy", int'(tx_empty), 0);
        put(8'h42, 1);
        @(negedge clk);
        check(hold_empty === 1'b0, "R6 byte waiting", int'(hold_empty), 0);
        drain("R6 frames delivered");

        // R8 R5: thresholds, then overflow
        tick_run = 1'b0;
        irq_en   = 1'b1;
        repeat (8) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            @(negedge clk);
            check(irq === 1'b1, "R8 empty queue requests", int'(irq), 1);
        end
        put(8'h90, 1);
        fill = 0;
        for (int b = 1; b <= 16; b++) begin
            put(8'(8'h90 + b), 1);
            fill++;
            if (fill == 3 || fill == 4 || fill == 8 || fill == 14 || fill == 16) begin
                for (int s = 0; s < 4; s++) begin
                    trig_sel = 2'(s);
                    @(negedge clk);
                    check(irq === (fill < lvl[s]), "R8 threshold compare", int'(irq), int'(fill < lvl[s]));
                end
            end
        end
        put(8'hEE, 0);
        @(negedge clk);
        check(hold_empty === 1'b0, "R5 queue still full", int'(hold_empty), 0);
        irq_en = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R9 irq gated", int'(irq), 0);
        drain("R5 R4 exactly accepted bytes sent in order");

        // R10: single holding register
        tick_run  = 1'b0;
        fifo_mode = 1'b0;
        irq_en    = 1'b1;
        trig_sel  = 2'd3;
        repeat (8) @(negedge clk);
        put(8'h11, 1);
        put(8'h22, 1);
        @(negedge clk);
        check(hold_empty === 1'b0, "R10 holding byte present", int'(hold_empty), 0);
        check(irq === 1'b0, "R10 threshold one", int'(irq), 0);
        put(8'h33, 0);
        drain("R10 second write dropped");

        summary();
    end

endmodule